// File: doc/BRIEF.md
# Wake event enable aggregator

This block collects up to sixteen wake sources and merges them into one active-low wake line. The sources form two byte-wide groups. The first group holds eight general-purpose inputs. The second group holds two ring-indicate lines, keyboard, mouse, a specific-key wake, two fan tachometers and one reserved slot. Each group has its own byte-wide enable register, written and read through a small register port. A source pulls the wake line low only when three conditions hold at once: its status input is pending, its enable bit is set, and the shared global enable input is high.

Status arrives from outside as level inputs. It is reported whatever the enable setting, and an enable of 0 only keeps that source off the wake line. The enable registers sit in the standby-power reset domain. They are cleared only by the standby reset and keep their contents through main-power reset and software resets. Only the read-data register of the register port belongs to the main-power domain. Each reset is asserted asynchronously and released through a two-flop synchronizer.

Top module: `wake_aggregator`

## Requirements
- R1: `wake_n` is 0 in the same cycle whenever `glob_en` is 1 and, for at least one index i, both enable bit i and status bit i are 1.
- R2: A source whose enable bit is 0 never pulls `wake_n` low, whatever its status input.
- R3: While `glob_en` is 0, `wake_n` is 1, whatever the enables and statuses.
- R4: When no source is both enabled and pending, `wake_n` is 1 (the line is active low).
- R5: Asserting `stby_rst_n` low clears both enable registers to 0x00.
- R6: Neither `main_rst_n` nor `sw_rst` changes either enable register.
- R7: Address 0 is the general-purpose group: bit i enables `gp_status[i]`. Address 1 is the auxiliary group: bit 1 ring 2, bit 2 ring 1, bit 3 keyboard, bit 4 mouse, bit 5 specific key, bit 6 fan 1, bit 7 fan 2, each enabling the `aux_status` bit of the same index. A write with `reg_wr`=1 takes effect at the clock edge.
- R8: Bit 0 of address 1 is reserved. Writes to it are ignored, it reads 0, and `aux_status[0]` never causes a wake.
- R9: Addresses 2 and 3 are reserved. They read 0x00, and writes to them change no enable.
- R10: `reg_rdata` loads the addressed register at the edge where `reg_rd` is 1, and holds its value otherwise. It is 0x00 during and after `main_rst_n`, and it is cleared at the edge where `sw_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| stby_rst_n | input | 1 | Standby-power reset, active low; clears the enables |
| main_rst_n | input | 1 | Main-power reset, active low; clears only the read data |
| sw_rst | input | 1 | Synchronous software reset; clears only the read data |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| gp_status | input | 8 | Pending status of the general-purpose sources |
| aux_status | input | 8 | Pending status of the auxiliary sources (bit 0 unused) |
| glob_en | input | 1 | Global wake enable |
| wake_n | output | 1 | Wake request, active low |

## Verification
A vector table sets patterns of enables, statuses and the global enable.

- A single matched pair in each group checks the index mapping of both groups.
- A pattern with every status set and every enable cleared separates "pending" from "enabled".
- Complementary masks, where every enabled bit has an idle status, catch an OR of the enables used in place of an AND.
- A match with the global enable low isolates the global gate.
- The reserved auxiliary bit is written and driven pending on its own, which shows whether it can leak onto the wake line.

Directed tests then toggle each reset against loaded enables and read the registers back, which separates the standby domain from the main domain.

// File: rtl/wake_agg_pkg.sv
package wake_agg_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_GRP = 2;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_GP_EN  = 2'd0,
    ADDR_AUX_EN = 2'd1,
    ADDR_RSV_A  = 2'd2,
    ADDR_RSV_B  = 2'd3
  } reg_addr_e;

  // Bits of each group that software may write; group 1 bit 0 is reserved.
  function automatic logic [DATA_W-1:0] grp_wmask(input int grp);
    logic [DATA_W-1:0] m;
    m = '1;
    if (grp == 1) m[0] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/wake_rst_sync.sv
module wake_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end
endmodule

// File: rtl/wake_en_reg.sv
module wake_en_reg #(
  parameter int              W     = 8,
  parameter logic [W-1:0]    WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  logic [W-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr_en) en_q <= en_d;
  end
endmodule

// File: rtl/wake_gate.sv
module wake_gate #(
  parameter int N = 16
) (
  input  logic [N-1:0] en,
  input  logic [N-1:0] status,
  input  logic         glob_en,
  output logic         wake_n
);
  logic [N-1:0] armed;

  always_comb begin
    armed  = en & status;
    wake_n = ~(glob_en & (|armed));
  end
endmodule

// File: rtl/wake_rd_port.sv
module wake_rd_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_clr,
  input  logic         rd_en,
  input  logic [W-1:0] sel_data,
  output logic [W-1:0] rdata
);
  logic [W-1:0] rdata_d;
  logic         load;

  always_comb begin
    load    = sw_clr | rd_en;
    rdata_d = sw_clr ? '0 : sel_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (load) rdata <= rdata_d;
  end
endmodule

// File: rtl/wake_aggregator.sv
module wake_aggregator
  import wake_agg_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int G = NUM_GRP
) (
  input  logic              clk,
  input  logic              stby_rst_n,
  input  logic              main_rst_n,
  input  logic              sw_rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [W-1:0]      gp_status,
  input  logic [W-1:0]      aux_status,
  input  logic              glob_en,
  output logic              wake_n
);
  localparam int N = W * G;

  logic         stby_sync_n;
  logic         main_sync_n;
  logic [N-1:0] en_all;
  logic [N-1:0] st_all;
  logic [W-1:0] rd_sel;

  wake_rst_sync u_stby_sync (.clk(clk), .arst_n(stby_rst_n), .srst_n(stby_sync_n));
  wake_rst_sync u_main_sync (.clk(clk), .arst_n(main_rst_n), .srst_n(main_sync_n));

  for (genvar g = 0; g < G; g++) begin : g_grp
    logic grp_wr;
    assign grp_wr = reg_wr && (reg_addr == ADDR_W'(g));
    wake_en_reg #(.W(W), .WMASK(grp_wmask(g))) u_en (
      .clk   (clk),
      .rst_n (stby_sync_n),
      .wr_en (grp_wr),
      .wdata (reg_wdata),
      .en_q  (en_all[g*W +: W])
    );
  end

  assign st_all = {aux_status, gp_status};

  always_comb begin
    rd_sel = '0;
    for (int g = 0; g < G; g++)
      if (reg_addr == ADDR_W'(g)) rd_sel = en_all[g*W +: W];
  end

  wake_rd_port #(.W(W)) u_rd (
    .clk      (clk),
    .rst_n    (main_sync_n),
    .sw_clr   (sw_rst),
    .rd_en    (reg_rd),
    .sel_data (rd_sel),
    .rdata    (reg_rdata)
  );

  wake_gate #(.N(N)) u_gate (
    .en      (en_all),
    .status  (st_all),
    .glob_en (glob_en),
    .wake_n  (wake_n)
  );
endmodule

// File: rtl/wake_aggregator_chk.sv
module wake_aggregator_chk #(
  parameter int W = 8,
  parameter int N = 16
) (
  input logic         clk,
  input logic         stby_rst_n,
  input logic         main_sync_n,
  input logic         sw_rst,
  input logic [1:0]   reg_addr,
  input logic         reg_wr,
  input logic         reg_rd,
  input logic [W-1:0] reg_rdata,
  input logic [N-1:0] en_all,
  input logic [N-1:0] st_all,
  input logic         glob_en,
  input logic         wake_n
);
  // R1
  a_r1_wake_has_cause: assert property (@(posedge clk) disable iff (!stby_rst_n)
    !wake_n |-> (glob_en && ((en_all & st_all) != '0)));
  // R3
  a_r3_global_gate: assert property (@(posedge clk) disable iff (!stby_rst_n)
    !glob_en |-> wake_n);
  // R5 R6 R9: enables move only on a write
  a_r6_en_hold: assert property (@(posedge clk) disable iff (!stby_rst_n)
    !reg_wr |=> $stable(en_all));
  // R8
  a_r8_reserved_bit: assert property (@(posedge clk) disable iff (!stby_rst_n)
    en_all[W] == 1'b0);
  // R9
  a_r9_reserved_read: assert property (@(posedge clk) disable iff (!stby_rst_n || !main_sync_n)
    (reg_rd && reg_addr[1]) |=> (reg_rdata == '0));
  // R10
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!stby_rst_n || !main_sync_n)
    (!reg_rd && !sw_rst) |=> $stable(reg_rdata));
endmodule

bind wake_aggregator wake_aggregator_chk #(.W(W), .N(N)) u_chk (
  .clk         (clk),
  .stby_rst_n  (stby_rst_n),
  .main_sync_n (main_sync_n),
  .sw_rst      (sw_rst),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .reg_rdata   (reg_rdata),
  .en_all      (en_all),
  .st_all      (st_all),
  .glob_en     (glob_en),
  .wake_n      (wake_n)
);

// File: tb/wake_aggregator_test.sv
module wake_aggregator_test;
  logic       clk = 1'b0;
  logic       stby_rst_n, main_rst_n, sw_rst;
  logic [1:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] gp_status, aux_status;
  logic       glob_en, wake_n;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wake_aggregator uut (.*);

  typedef struct packed {
    logic [7:0] ge; logic [7:0] ae; logic [7:0] gs; logic [7:0] as_; logic g; logic exp_n;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 1'b1, 1'b1},  // R2 all disabled
    '{8'h01, 8'h00, 8'h01, 8'h00, 1'b1, 1'b0},  // R1 gp bit0
    '{8'h01, 8'h00, 8'h01, 8'h00, 1'b0, 1'b1},  // R3 global off
    '{8'h80, 8'h00, 8'h7F, 8'h00, 1'b1, 1'b1},  // R4 no overlap
    '{8'h00, 8'h80, 8'h00, 8'h80, 1'b1, 1'b0},  // R7 fan 2
    '{8'h00, 8'h01, 8'h00, 8'h01, 1'b1, 1'b1},  // R8 reserved bit
    '{8'h00, 8'hFF, 8'hFF, 8'h02, 1'b1, 1'b0},  // R7 ring 2
    '{8'hF0, 8'h0F, 8'h0F, 8'hF0, 1'b1, 1'b1},  // R2 complementary
    '{8'hAA, 8'h55, 8'h55, 8'hAA, 1'b1, 1'b1},  // R2 interleaved
    '{8'hAA, 8'h00, 8'h8A, 8'h00, 1'b1, 1'b0}   // R1 partial overlap
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  initial begin
    logic [7:0] v;
    stby_rst_n = 0; main_rst_n = 0; sw_rst = 0; reg_addr = 0; reg_wr = 0; reg_rd = 0;
    reg_wdata = 0; gp_status = 8'hFF; aux_status = 8'hFF; glob_en = 1;
    repeat (3) @(negedge clk);
    stby_rst_n = 1; main_rst_n = 1;
    repeat (4) @(negedge clk);
    // R5 reset state
    check("R5 wake_n after reset", {7'd0, wake_n}, 8'h01);
    rd(2'd0, v); check("R5 gp enable reset", v, 8'h00);
    rd(2'd1, v); check("R5 aux enable reset", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VEC[i].ge);
      wr(2'd1, VEC[i].ae);
      gp_status = VEC[i].gs; aux_status = VEC[i].as_; glob_en = VEC[i].g;
      #1;
      check($sformatf("R1/R2/R3/R4/R7/R8 vector %0d wake_n", i), {7'd0, wake_n}, {7'd0, VEC[i].exp_n});
      rd(2'd1, v); check($sformatf("R8 aux readback vector %0d", i), v, VEC[i].ae & 8'hFE);
    end

    // R9 reserved addresses
    wr(2'd0, 8'h3C); wr(2'd1, 8'hC6);
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    rd(2'd2, v); check("R9 reserved read A", v, 8'h00);
    rd(2'd3, v); check("R9 reserved read B", v, 8'h00);
    rd(2'd0, v); check("R9 gp unchanged", v, 8'h3C);
    rd(2'd1, v); check("R9 aux unchanged", v, 8'hC6);

    // R10 hold without read
    wr(2'd1, 8'h12);
    @(negedge clk); check("R10 rdata holds", reg_rdata, 8'hC6);
    rd(2'd1, v); check("R10 rdata loads", v, 8'h12);

    // R6 / R10 main reset and soft reset
    gp_status = 8'h00; aux_status = 8'h02; glob_en = 1;
    @(negedge clk); main_rst_n = 0;
    #1; check("R10 rdata cleared by main reset", reg_rdata, 8'h00);
    wr(2'd0, 8'h00); // write still lands: enables live in standby domain
    wr(2'd0, 8'h3C);
    repeat (2) @(negedge clk);
    check("R6 wake_n during main reset", {7'd0, wake_n}, 8'h00);
    main_rst_n = 1;
    repeat (4) @(negedge clk);
    check("R10 rdata after main reset", reg_rdata, 8'h00);
    rd(2'd1, v); check("R6 aux kept over main reset", v, 8'h12);
    @(negedge clk); sw_rst = 1;
    @(negedge clk); sw_rst = 0;
    check("R10 rdata cleared by sw_rst", reg_rdata, 8'h00);
    rd(2'd0, v); check("R6 gp kept over sw_rst", v, 8'h3C);

    // R5 standby reset clears enables
    @(negedge clk); stby_rst_n = 0;
    #1; check("R5 wake released by standby reset", {7'd0, wake_n}, 8'h01);
    repeat (2) @(negedge clk); stby_rst_n = 1;
    repeat (4) @(negedge clk);
    rd(2'd0, v); check("R5 gp cleared", v, 8'h00);
    rd(2'd1, v); check("R5 aux cleared", v, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule